// File: doc/BRIEF.md
# Byte-Wide Passive FPGA Configuration Sequencer

This block is the host side of a byte-wide passive configuration link. It takes the configuration image from an upstream valid/ready byte stream and sends it into a target FPGA whose on-chip decompression or decryption is enabled. First it pulses the target's program line low. It then waits for the target to report that it is ready. After that it clocks every byte into the target over four clock periods. Finally it keeps clocking until the target reports that loading is complete.

The target clock is built from the system clock. Its high and low phases each last a parameterised number of system cycles. The data bus changes only while the target clock is low. If the upstream stream has no byte ready, the clock stops in its low phase until a byte arrives. The sequence ends in one of two terminal states. `ST_DONE` releases the data bus. `ST_FAIL` raises the error flag. A new `start` pulse in either terminal state, or in `ST_IDLE`, begins another attempt.

The states are `ST_IDLE`, `ST_PULSE`, `ST_WAIT_RDY`, `ST_FETCH`, `ST_CLOCK`, `ST_TAIL`, `ST_DONE` and `ST_FAIL`. The transitions are:
- `start` moves IDLE, DONE or FAIL to PULSE.
- PULSE moves to WAIT_RDY once the pulse count has run out.
- WAIT_RDY moves to FETCH when ready is seen, and to FAIL when the timeout expires.
- FETCH moves to CLOCK when a byte is accepted.
- CLOCK moves to FETCH after the fourth falling edge of a byte that is not the last.
- CLOCK moves to TAIL after the fourth falling edge of the last byte.
- TAIL moves to DONE when the loaded flag is seen during a low phase that is not about to rise.
- TAIL moves to FAIL when the extra-period budget runs out.
- FETCH, CLOCK and TAIL move to FAIL when ready drops.

Top module: `fpp_cfg_host`

## Requirements
- R1: After reset the outputs take these values: `tgt_prog_n` high, `tgt_clk` low, `tgt_data_oe` low, and `busy`, `done`, `error` and `s_ready` all low.
- R2: `start` drives `tgt_prog_n` low for exactly `PULSE_CYC` system cycles and then releases it high. `busy` is high from the first of these cycles.
- R3: No rising edge of `tgt_clk` occurs before `tgt_ok` has been seen high after the program pulse. If `tgt_ok` is still low `RDY_TIMEOUT` cycles after release, the block enters `ST_FAIL` with `error` high, and `tgt_clk` never rises in that attempt.
- R4: Each accepted byte stays on `tgt_data` across exactly four consecutive rising edges of `tgt_clk`. Bytes go out in the order they were accepted. `tgt_data` never changes while `tgt_clk` is high.
- R5: Every high phase of `tgt_clk` lasts exactly `CLK_HALF` system cycles. Every low phase lasts at least `CLK_HALF` cycles.
- R6: When a new byte is due and `s_valid` is low, `s_ready` is high, `tgt_clk` stays low and no rising edge occurs until a byte is accepted.
- R7: If `tgt_ok` goes low while bytes or extra periods are being clocked, the attempt ends in `ST_FAIL` with `error` high.
- R8: After the last byte (`s_last` high on its handshake), `tgt_clk` keeps toggling. Once `tgt_loaded` is seen high, the block enters `ST_DONE`: `done` is high, `tgt_clk` is low, `tgt_data_oe` is low and `tgt_prog_n` is high.
- R9: If `tgt_loaded` is not seen high within `TAIL_CLKS` extra clock periods, the block enters `ST_FAIL`. Exactly `TAIL_CLKS` extra rising edges follow the last data edge.
- R10: `start` restarts the sequence from `ST_IDLE`, `ST_DONE` or `ST_FAIL` and clears `done` and `error`. `start` has no effect while `busy` is high.
- R11: `done` and `error` are never high together, and neither is high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration attempt |
| s_valid | input | 1 | Upstream byte valid |
| s_data | input | DATA_W | Upstream byte |
| s_last | input | 1 | Marks the final byte of the image |
| s_ready | output | 1 | Block accepts the upstream byte this cycle |
| tgt_prog_n | output | 1 | Active-low program request to the target |
| tgt_clk | output | 1 | Configuration clock to the target |
| tgt_data | output | DATA_W | Configuration data to the target |
| tgt_data_oe | output | 1 | Output enable for the data bus; low means released |
| tgt_ok | input | 1 | Target ready/healthy status, low on reset or fault |
| tgt_loaded | input | 1 | Target reports the whole image was accepted |
| busy | output | 1 | An attempt is in progress |
| done | output | 1 | Last attempt completed |
| error | output | 1 | Last attempt failed |

## Verification
The checks rely on a few assumptions about the target's inputs. `tgt_ok` must fall within a few cycles of the program pulse, and it must stay low for the rest of the pulse, so that an old high level cannot pass the two-stage synchronizer. `tgt_loaded` must rise early enough in the extra-period window that at least two low phases remain in which it can be seen. The target model in the bench obeys both assumptions. It lowers both status lines one cycle after the pulse begins. It raises the loaded flag at least three extra periods before the budget runs out. The upstream stream holds `s_data` steady while `s_valid` is high and waiting.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT_RDY,
        ST_FETCH,
        ST_CLOCK,
        ST_TAIL,
        ST_DONE,
        ST_FAIL
    } fpp_state_t;

    // Target clock periods spent on one byte while decompression/decryption is on
    localparam int unsigned BEATS_PER_BYTE = 4;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fpp_sync.sv
module fpp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];

endmodule

// File: rtl/fpp_dclk_gen.sv
module fpp_dclk_gen #(
    parameter int unsigned HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic dclk,
    output logic rise_nxt,
    output logic fall_nxt
);

    localparam int unsigned PW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [PW-1:0] ph;
    logic          lvl;
    logic          ph_end;

    assign ph_end   = (ph == PW'(HALF - 1));
    assign rise_nxt = run && ph_end && !lvl;
    assign fall_nxt = run && ph_end && lvl;
    assign dclk     = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph  <= '0;
            lvl <= 1'b0;
        end else if (!run) begin
            ph  <= '0;
            lvl <= 1'b0;
        end else if (ph_end) begin
            ph  <= '0;
            lvl <= !lvl;
        end else begin
            ph  <= ph + 1'b1;
        end
    end

endmodule

// File: rtl/fpp_cfg_host.sv
module fpp_cfg_host
    import fpp_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CLK_HALF    = 4,
    parameter int unsigned PULSE_CYC   = 256,
    parameter int unsigned RDY_TIMEOUT = 100000,
    parameter int unsigned TAIL_CLKS   = 64,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              tgt_prog_n,
    output logic              tgt_clk,
    output logic [DATA_W-1:0] tgt_data,
    output logic              tgt_data_oe,
    input  logic              tgt_ok,
    input  logic              tgt_loaded,
    output logic              busy,
    output logic              done,
    output logic              error
);

    localparam int unsigned TW = $clog2(max3(PULSE_CYC, RDY_TIMEOUT, TAIL_CLKS) + 1);
    localparam int unsigned BW = $clog2(BEATS_PER_BYTE);

    fpp_state_t        st, st_nxt;
    logic [TW-1:0]     cnt;
    logic [BW-1:0]     beats;
    logic [DATA_W-1:0] data_q;
    logic              last_q;
    logic              ok_s, loaded_s;
    logic              run, dclk, rise_nxt, fall_nxt;
    logic              accept, byte_end, cnt_en;

    fpp_sync #(.STAGES(SYNC_STAGES)) u_sync_ok (
        .clk(clk), .rst_n(rst_n), .d(tgt_ok), .q(ok_s)
    );

    fpp_sync #(.STAGES(SYNC_STAGES)) u_sync_loaded (
        .clk(clk), .rst_n(rst_n), .d(tgt_loaded), .q(loaded_s)
    );

    fpp_dclk_gen #(.HALF(CLK_HALF)) u_dclk (
        .clk(clk), .rst_n(rst_n), .run(run),
        .dclk(dclk), .rise_nxt(rise_nxt), .fall_nxt(fall_nxt)
    );

    assign accept   = (st == ST_FETCH) && ok_s && s_valid;
    assign byte_end = fall_nxt && (beats == BW'(BEATS_PER_BYTE - 1));
    assign cnt_en   = (st == ST_PULSE) || (st == ST_WAIT_RDY) || ((st == ST_TAIL) && fall_nxt);

    // next-state decision
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) st_nxt = ST_PULSE;
            end
            ST_PULSE: begin
                if (cnt == TW'(PULSE_CYC - 1)) st_nxt = ST_WAIT_RDY;
            end
            ST_WAIT_RDY: begin
                if (ok_s)                             st_nxt = ST_FETCH;
                else if (cnt == TW'(RDY_TIMEOUT - 1)) st_nxt = ST_FAIL;
            end
            ST_FETCH: begin
                if (!ok_s)       st_nxt = ST_FAIL;
                else if (accept) st_nxt = ST_CLOCK;
            end
            ST_CLOCK: begin
                if (!ok_s)         st_nxt = ST_FAIL;
                else if (byte_end) st_nxt = last_q ? ST_TAIL : ST_FETCH;
            end
            ST_TAIL: begin
                if (!ok_s)                                    st_nxt = ST_FAIL;
                else if (loaded_s && !dclk && !rise_nxt)      st_nxt = ST_DONE;
                else if (fall_nxt && cnt == TW'(TAIL_CLKS - 1)) st_nxt = ST_FAIL;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // timers, beat count and byte holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            beats  <= '0;
            data_q <= '0;
            last_q <= 1'b0;
        end else begin
            if (st_nxt != st) cnt <= '0;
            else if (cnt_en)  cnt <= cnt + 1'b1;

            if (accept) begin
                data_q <= s_data;
                last_q <= s_last;
                beats  <= '0;
            end else if ((st == ST_CLOCK) && fall_nxt) begin
                beats  <= beats + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tgt_prog_n  = (st != ST_PULSE);
        run         = (st == ST_CLOCK) || (st == ST_TAIL);
        s_ready     = (st == ST_FETCH) && ok_s;
        tgt_data_oe = (st == ST_FETCH) || (st == ST_CLOCK) || (st == ST_TAIL);
        busy        = (st == ST_PULSE) || (st == ST_WAIT_RDY) || tgt_data_oe;
        done        = (st == ST_DONE);
        error       = (st == ST_FAIL);
        tgt_clk     = dclk;
        tgt_data    = data_q;
    end

endmodule

// File: rtl/fpp_cfg_host_chk.sv
module fpp_cfg_host_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned HALF   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tgt_prog_n,
    input logic              tgt_clk,
    input logic [DATA_W-1:0] tgt_data,
    input logic              tgt_data_oe,
    input logic              s_ready,
    input logic              busy,
    input logic              done,
    input logic              error
);

    logic [15:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_run <= '0;
        else if (tgt_clk) hi_run <= hi_run + 1'b1;
        else              hi_run <= '0;
    end

    a_r5_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_clk |-> (hi_run < 16'(HALF)));

    a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_clk |-> $stable(tgt_data));

    a_r2_quiet_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_prog_n |-> (!tgt_clk && !tgt_data_oe));

    a_r6_pause_low: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !tgt_clk);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!tgt_clk && !tgt_data_oe && tgt_prog_n));

    a_r11_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error) && !(busy && (done || error)));

endmodule

bind fpp_cfg_host fpp_cfg_host_chk #(.DATA_W(DATA_W), .HALF(CLK_HALF)) u_chk (
    .clk(clk), .rst_n(rst_n), .tgt_prog_n(tgt_prog_n), .tgt_clk(tgt_clk),
    .tgt_data(tgt_data), .tgt_data_oe(tgt_data_oe), .s_ready(s_ready),
    .busy(busy), .done(done), .error(error)
);

// File: tb/fpp_cfg_host_bench.sv
`timescale 1ns/1ps
module fpp_cfg_host_bench;

    localparam int HALF  = 2;
    localparam int PULSE = 10;
    localparam int RDYTO = 60;
    localparam int TAIL  = 6;
    localparam int NEVER = 255;

    // columns: bytes, gap before each byte, ready delay, loaded offset, drop edge, expect done
    localparam int VEC [6][6] = '{
        '{3, 0,   5,     2, 0, 1},
        '{5, 7,  20,     0, 0, 1},
        '{1, 3,   1,     3, 0, 1},
        '{2, 1,   4, NEVER, 0, 0},
        '{2, 0, 200,     0, 0, 0},
        '{3, 2,   4,     0, 6, 0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_last = 1'b0;
    logic       s_ready, tgt_prog_n, tgt_clk, tgt_data_oe, busy, done, error;
    logic [7:0] tgt_data;
    logic       tgt_ok = 1'b0;
    logic       tgt_loaded = 1'b0;

    int checks = 0;
    int fails  = 0;

    // target model settings
    int m_sdelay = 0, m_done_edge = 0, m_drop_edge = 0;
    // target model observations
    int rises = 0, rel = 0, lowc = 0, pulse_len = 0, hi_len = 0, lo_len = 0;
    bit prev_clk = 0, hi_bad = 0, lo_bad = 0, seen_ok = 0, early = 0, dropped = 0;
    logic [7:0] rxb [256];

    always #4 clk = ~clk;

    fpp_cfg_host #(
        .DATA_W(8), .CLK_HALF(HALF), .PULSE_CYC(PULSE),
        .RDY_TIMEOUT(RDYTO), .TAIL_CLKS(TAIL), .SYNC_STAGES(2)
    ) u_fpp_cfg_host (
        .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid), .s_data(s_data),
        .s_last(s_last), .s_ready(s_ready), .tgt_prog_n(tgt_prog_n), .tgt_clk(tgt_clk),
        .tgt_data(tgt_data), .tgt_data_oe(tgt_data_oe), .tgt_ok(tgt_ok),
        .tgt_loaded(tgt_loaded), .busy(busy), .done(done), .error(error)
    );

    // target model, evaluated away from the active edge
    always @(negedge clk) begin
        if (!tgt_prog_n) begin
            tgt_ok <= 1'b0; tgt_loaded <= 1'b0; rel <= 0; rises <= 0;
            lowc <= lowc + 1; hi_bad <= 0; lo_bad <= 0; hi_len <= 0; lo_len <= 0;
            seen_ok <= 0; early <= 0; dropped <= 0;
        end else begin
            if (lowc != 0) begin pulse_len <= lowc; lowc <= 0; end
            if (rel < m_sdelay) rel <= rel + 1;
            else if (!dropped) tgt_ok <= 1'b1;
            if (tgt_ok) seen_ok <= 1;
            if (m_drop_edge != 0 && rises >= m_drop_edge) begin tgt_ok <= 1'b0; dropped <= 1; end
            if (m_done_edge != 0 && rises >= m_done_edge) tgt_loaded <= 1'b1;
            if (tgt_clk && !prev_clk) begin
                if (rises < 256) rxb[rises] <= tgt_data;
                rises <= rises + 1;
                if (!seen_ok && !tgt_ok) early <= 1;
                if (lo_len < HALF) lo_bad <= 1;
                hi_len <= 1;
            end else if (tgt_clk) begin
                hi_len <= hi_len + 1;
            end else if (prev_clk) begin
                if (hi_len != HALF) hi_bad <= 1;
                lo_len <= 1;
            end else begin
                lo_len <= lo_len + 1;
            end
        end
        prev_clk <= tgt_clk;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int s, input int i);
        return 8'((8'h5A ^ (s * 29 + i * 13 + i * i)) & 8'hFF);
    endfunction

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end();
        int w = 0;
        while (!(done || error) && w < 3000) begin @(negedge clk); w++; end
    endtask

    task automatic run_session(input int s);
        int n, gap, sd, dx, dr;
        n = VEC[s][0]; gap = VEC[s][1]; sd = VEC[s][2]; dx = VEC[s][3]; dr = VEC[s][4];
        m_sdelay = sd;
        m_done_edge = (dx == NEVER) ? 0 : 4 * n + dx;
        m_drop_edge = dr;
        pulse_start();
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    repeat (gap) @(negedge clk);
                    s_valid = 1'b1; s_data = pat(s, i); s_last = (i == n - 1);
                    while (!s_ready && !error) @(negedge clk);
                    if (error) break;
                    @(negedge clk);
                    s_valid = 1'b0; s_last = 1'b0;
                end
                s_valid = 1'b0; s_last = 1'b0;
            end
            wait_end();
        join
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int bad, badp;
        repeat (5) @(negedge clk);
        // R1: state straight after reset
        chk(tgt_prog_n == 1 && tgt_clk == 0 && tgt_data_oe == 0, "R1", "target pins at reset", {tgt_prog_n, tgt_clk, tgt_data_oe}, 3'b100);
        chk(!busy && !done && !error && !s_ready, "R1", "status at reset", {busy, done, error, s_ready}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // table of scenarios walked by one loop
        for (int s = 0; s < 6; s++) begin
            run_session(s);
            chk(!(done && error) && !busy, "R11", $sformatf("flags s%0d", s), {busy, done, error}, 0);
            chk(pulse_len == PULSE, "R2", $sformatf("program pulse s%0d", s), pulse_len, PULSE);
            chk(early == 0, "R3", $sformatf("edge before ready s%0d", s), early, 0);
            chk(hi_bad == 0 && lo_bad == 0, "R5", $sformatf("clock phases s%0d", s), {hi_bad, lo_bad}, 0);
            if (VEC[s][5] == 1) begin
                chk(done == 1, "R8", $sformatf("done s%0d", s), done, 1);
                chk(!tgt_clk && !tgt_data_oe && tgt_prog_n, "R8", $sformatf("pins after done s%0d", s), {tgt_clk, tgt_data_oe}, 0);
                bad = 0;
                for (int e = 0; e < 4 * VEC[s][0]; e++)
                    if (rxb[e] !== pat(s, e / 4)) bad++;
                chk(bad == 0, "R4", $sformatf("byte repeats s%0d", s), bad, 0);
            end else begin
                chk(error == 1, "R7", $sformatf("error s%0d", s), error, 1);
                if (VEC[s][3] == NEVER)
                    chk(rises == 4 * VEC[s][0] + TAIL, "R9", "extra edges", rises, 4 * VEC[s][0] + TAIL);
                if (VEC[s][2] > RDYTO)
                    chk(rises == 0, "R3", "no edge on ready timeout", rises, 0);
            end
        end

        // R6 pause while no byte, R10 start ignored while busy
        m_sdelay = 3; m_done_edge = 8; m_drop_edge = 0;
        pulse_start();
        s_valid = 1'b1; s_data = 8'hC3; s_last = 1'b0;
        while (!s_ready) @(negedge clk);
        @(negedge clk); s_valid = 1'b0;
        while (!s_ready) @(negedge clk);
        bad = 0; badp = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (tgt_clk || !s_ready || !tgt_data_oe) bad++;
            if (!tgt_prog_n) badp++;
            start = (k == 5);
        end
        start = 1'b0;
        chk(bad == 0, "R6", "clock held low while waiting", bad, 0);
        chk(rises == 4, "R6", "edges during pause", rises, 4);
        chk(badp == 0 && busy, "R10", "start ignored while busy", badp, 0);
        s_valid = 1'b1; s_data = 8'h3C; s_last = 1'b1;
        while (!s_ready) @(negedge clk);
        @(negedge clk); s_valid = 1'b0; s_last = 1'b0;
        wait_end();
        chk(done == 1, "R8", "done after pause", done, 1);
        chk(rxb[0] == 8'hC3 && rxb[3] == 8'hC3 && rxb[4] == 8'h3C && rxb[7] == 8'h3C, "R4", "order across pause", rxb[4], 8'h3C);

        // R10 restart from the done state clears the flag
        pulse_start();
        chk(!done && busy && !tgt_prog_n, "R10", "restart from done", {done, busy, tgt_prog_n}, 3'b010);

        // R1 reset in the middle of an attempt
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(tgt_prog_n && !tgt_clk && !tgt_data_oe && !busy && !done && !error, "R1", "mid-run reset",
            {tgt_prog_n, tgt_clk, tgt_data_oe, busy, done, error}, 6'b100000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule